// File: doc/BRIEF.md
# SPI Serial Clock and Pre-Clock Delay Generator

This block produces the serial clock of an SPI-style master and decides how long chip-select is held active before the first clock edge. A baud register inside the block, loaded through a one-cycle write strobe, sets the half period of the serial clock in system clocks. When a transfer starts, the block copies that value and the delay settings from the current inputs. It raises chip-select, waits out the pre-clock delay, and then toggles the serial clock for a fixed number of bits.

For each transfer, a select bit picks one of two delays. The first is half of one serial-clock period. The second is a programmable count with two special codes. On every clock edge the block gives a one-cycle strobe, one kind for leading edges and one kind for trailing edges, so that a shift register can load and capture data. The idle level of the clock follows a polarity input.

Top module: `spi_sck_gen`

## Requirements
- R1: With a latched divider value N in 2..255, each serial-clock half period lasts exactly N system clocks, so the clock frequency is the system clock divided by 2N.
- R2: A divider value of 0 or 1 turns the generator off. A start pulse is then ignored: cs_active stays low and sck stays at its idle level.
- R3: After reset the baud register holds 4, so a start with no register write gives a 4-clock half period. After reset, cs_active, dly_done and both strobes are low and sck equals cpol.
- R4: When dly_sel is 0 at the start pulse, the pre-clock delay equals the divider value (half a serial-clock period), and dly_cnt has no effect.
- R5: When dly_sel is 1 and dly_cnt is in 2..127, the pre-clock delay lasts dly_cnt system clocks.
- R6: When dly_sel is 1 and dly_cnt is 0, the pre-clock delay lasts 128 system clocks.
- R7: When dly_sel is 1 and dly_cnt is 1, the pre-clock delay lasts 2 system clocks, the same as a value of 2.
- R8: The pre-clock delay is counted from the cycle in which cs_active goes high. No sck edge occurs before dly_done rises. The first sck edge and the rise of dly_done happen in the same cycle.
- R9: A transfer has NBITS (default 8) leading and NBITS trailing edges. lead_stb or trail_stb is high for exactly the one cycle in which sck takes its new level, and the two are never high together. At the last trailing edge, sck returns to cpol and cs_active and dly_done drop.
- R10: A register write or a change of dly_sel/dly_cnt during a transfer does not alter that transfer. It takes effect at the next start. A start pulse during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle write strobe for the baud register |
| cfg_baud | input | 8 | Value written into the baud register |
| dly_sel | input | 1 | Per-transfer delay choice: 0 half period, 1 programmable count |
| dly_cnt | input | 7 | Programmable pre-clock delay count |
| start | input | 1 | Transfer start strobe |
| cpol | input | 1 | Idle level of sck |
| sck | output | 1 | Serial clock |
| cs_active | output | 1 | High while a transfer owns chip-select |
| dly_done | output | 1 | High once the pre-clock delay has elapsed |
| lead_stb | output | 1 | One-cycle pulse on each leading sck edge |
| trail_stb | output | 1 | One-cycle pulse on each trailing sck edge |

## Verification
The edge-direction and idle-level assertions assume that cpol does not change while cs_active is high. The stimulus therefore changes cpol only between transfers, when the block is idle. The assertions also assume that start is a single-cycle pulse. The stimulus drives every strobe, including the start pulse sent during a transfer and the register write sent during a transfer, for exactly one cycle. All inputs change on the falling clock edge.

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int NBITS   = 8,
  parameter int DIVW    = 8,
  parameter int DLYW    = 7,
  parameter int RST_DIV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [DIVW-1:0] cfg_baud,
  input  logic            dly_sel,
  input  logic [DLYW-1:0] dly_cnt,
  input  logic            start,
  input  logic            cpol,
  output logic            sck,
  output logic            cs_active,
  output logic            dly_done,
  output logic            lead_stb,
  output logic            trail_stb
);
  localparam int CW    = (DIVW > DLYW + 1) ? DIVW : DLYW + 1;
  localparam int EW    = $clog2(2 * NBITS + 1);
  localparam int DLY_Z = 1 << DLYW;

  typedef enum logic [1:0] {S_IDLE, S_DELAY, S_SHIFT} st_t;

  st_t             st;
  logic [DIVW-1:0] baud_q, div_l;
  logic [CW-1:0]   cnt, dly_eff;
  logic [EW-1:0]   edges;
  logic            ph;

  always_comb begin
    if (!dly_sel)            dly_eff = CW'(baud_q);
    else if (dly_cnt == '0)  dly_eff = CW'(DLY_Z);
    else if (dly_cnt == 1)   dly_eff = CW'(2);
    else                     dly_eff = CW'(dly_cnt);
  end

  assign sck = cpol ^ ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      baud_q    <= DIVW'(RST_DIV);
      div_l     <= '0;
      cnt       <= '0;
      edges     <= '0;
      ph        <= 1'b0;
      cs_active <= 1'b0;
      dly_done  <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
      if (cfg_wr) baud_q <= cfg_baud;
      case (st)
        S_IDLE: if (start && baud_q >= DIVW'(2)) begin
          st        <= S_DELAY;
          cs_active <= 1'b1;
          div_l     <= baud_q;
          cnt       <= dly_eff - CW'(1);
        end
        S_DELAY: if (cnt == '0) begin
          st       <= S_SHIFT;
          dly_done <= 1'b1;
          ph       <= 1'b1;
          lead_stb <= 1'b1;
          edges    <= EW'(1);
          cnt      <= CW'(div_l) - CW'(1);
        end else cnt <= cnt - CW'(1);
        S_SHIFT: if (cnt == '0) begin
          ph        <= ~ph;
          lead_stb  <= ~ph;
          trail_stb <= ph;
          edges     <= edges + EW'(1);
          cnt       <= CW'(div_l) - CW'(1);
          if (edges + EW'(1) == EW'(2 * NBITS)) begin
            st        <= S_IDLE;
            cs_active <= 1'b0;
            dly_done  <= 1'b0;
          end
        end else cnt <= cnt - CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> sck == cpol);
  p_no_start_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && baud_q < DIVW'(2)) |=> !cs_active);
  p_quiet_during_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && !dly_done) |-> sck == cpol);
  p_first_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dly_done) |-> lead_stb);
  p_done_in_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dly_done |-> cs_active);
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));
  p_lead_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (ph && !$past(ph)));
  p_trail_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (!ph && $past(ph)));
endmodule

// File: tb/tb_spi_sck_gen.sv
`timescale 1ns/1ps
module tb_spi_sck_gen;
  localparam int NB = 8;
  logic clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0, dly_sel = 1'b0, start = 1'b0, cpol = 1'b0;
  logic [7:0] cfg_baud = '0;
  logic [6:0] dly_cnt = '0;
  logic sck, cs_active, dly_done, lead_stb, trail_stb;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_sck_gen #(.NBITS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_baud(cfg_baud),
    .dly_sel(dly_sel), .dly_cnt(dly_cnt), .start(start), .cpol(cpol),
    .sck(sck), .cs_active(cs_active), .dly_done(dly_done),
    .lead_stb(lead_stb), .trail_stb(trail_stb));

  // {div[24:17], dsel[16], dly[15:9], cpol[8], expected delay[7:0]}
  localparam logic [24:0] VEC [8] = '{
    {8'd4,   1'b0, 7'd0,   1'b0, 8'd4},
    {8'd2,   1'b1, 7'd10,  1'b0, 8'd10},
    {8'd3,   1'b1, 7'd0,   1'b1, 8'd128},
    {8'd5,   1'b1, 7'd1,   1'b0, 8'd2},
    {8'd6,   1'b1, 7'd2,   1'b1, 8'd2},
    {8'd2,   1'b1, 7'd127, 1'b0, 8'd127},
    {8'd255, 1'b0, 7'd50,  1'b0, 8'd255},
    {8'd7,   1'b0, 7'd1,   1'b1, 8'd7}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_baud = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic xfer(input int expd, input int half, input string req, input bit disturb);
    int k, h, lc, tc;
    logic s;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cs_active == 1'b1, "R8", "cs_active after start", cs_active, 1);
    chk(sck == cpol && !dly_done, "R8", "sck quiet at cs rise", sck, cpol);
    if (disturb) begin
      cfg_wr = 1'b1; cfg_baud = 8'd9; start = 1'b1;
      dly_sel = ~dly_sel; dly_cnt = dly_cnt + 7'd33;
    end
    k = 0;
    while (!dly_done && k < 1000) begin
      @(negedge clk); cfg_wr = 1'b0; start = 1'b0; k++;
    end
    chk(k == expd, req, "pre-clock delay", k, expd);
    chk(sck == ~cpol && lead_stb, "R8", "first edge with dly_done", sck, ~cpol);
    h = 0; s = sck;
    while (sck == s && h < 1000) begin @(negedge clk); h++; end
    chk(h == half, "R1", "half period", h, half);
    lc = 1; tc = int'(trail_stb);
    while (cs_active && lc < 100) begin
      @(negedge clk); lc += int'(lead_stb); tc += int'(trail_stb);
    end
    chk(lc == NB, "R9", "leading edges", lc, NB);
    chk(tc == NB, "R9", "trailing edges", tc, NB);
    chk(sck == cpol && !dly_done, "R9", "idle after transfer", sck, cpol);
  endtask

  task automatic try_disabled(input logic [7:0] v);
    bit bad = 1'b0;
    wr(v);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (cs_active || sck != cpol || lead_stb) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, "R2", "start ignored with disabled divider", int'(v), 0);
  endtask

  initial begin
    #1_200_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cs_active && !dly_done && !lead_stb && !trail_stb && sck == cpol,
        "R3", "reset outputs", int'(cs_active), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: default divider 4 gives 4-clock delay and half period
    xfer(4, 4, "R3", 1'b0);
    foreach (VEC[i]) begin
      wr(VEC[i][24:17]);
      dly_sel = VEC[i][16]; dly_cnt = VEC[i][15:9]; cpol = VEC[i][8];
      @(negedge clk);
      chk(sck == cpol, "R9", "idle level follows cpol", sck, cpol);
      xfer(int'(VEC[i][7:0]), int'(VEC[i][24:17]),
           !VEC[i][16] ? "R4" : (VEC[i][15:9] == 0 ? "R6" : (VEC[i][15:9] == 1 ? "R7" : "R5")), 1'b0);
    end
    cpol = 1'b0;
    try_disabled(8'd0);
    try_disabled(8'd1);
    // R10: mid-transfer changes and start are ignored until the next start
    wr(8'd3); dly_sel = 1'b1; dly_cnt = 7'd20;
    xfer(20, 3, "R10", 1'b1);
    repeat (3) @(negedge clk);
    chk(!cs_active, "R10", "start during transfer not kept", cs_active, 0);
    dly_sel = 1'b0;
    xfer(9, 9, "R10", 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule